// File: doc/BRIEF.md
# Single-Cycle Processor Core

This block is a 32-bit processor core that retires one instruction on every clock edge. It executes a small integer subset: register-register add, subtract, and, or and signed set-less-than, word load and store with a signed 16-bit displacement, branch-if-equal and an absolute jump. Instruction fetch, register read, ALU work, data memory access and register write-back all settle combinationally inside one cycle. The new PC and every architectural write land together on the next rising edge.

Instruction and data storage are word arrays inside the core. A load port fills them while the core is held in reset. The register file has 32 entries, two read ports, one write port and a third read port for inspection. Decoding is done in two levels. A main decoder turns the opcode into datapath controls plus a 2-bit operation class. An ALU decoder then combines that class with the function field to pick the ALU operation. The next PC is chosen among PC+4, the branch target and the jump target, each computed by its own adder or by wiring. The commit outputs show, before each edge, the register and memory writes that the edge is about to perform.

Top module: `cpu_core`

## Requirements
- R1: While `rst_n` is low, the PC reads 0 and no register or memory write is reported or performed. `rst_n` is synchronised by two flops, so the instruction at address 0 commits on the third rising edge after `rst_n` rises. Asserting `rst_n` forces the PC to 0 at once.
- R2: Opcode 000000 is register-register. The destination is bits [15:11] (rd), the sources are rs [25:21] and rt [20:16], and the function field is bits [5:0]. Function 100000 adds, 100010 subtracts (rs minus rt), 100100 ANDs and 100101 ORs.
- R3: Function 101010 writes 1 to rd when rs is less than rt as signed two's-complement numbers, and 0 otherwise (equal operands give 0).
- R4: Opcode 100011 loads into rt the data word at byte address rs + sign-extended bits [15:0]. The word index is address bits [DMEM_AW+1:2].
- R5: Opcode 101011 stores rt to the word at byte address rs + sign-extended bits [15:0] and writes no register.
- R6: Opcode 000100 compares rs with rt. When they are equal, the next PC is PC+4 + (sign-extended bits [15:0] shifted left 2); otherwise it is PC+4. It writes neither registers nor memory.
- R7: Opcode 000010 sets the next PC to {(PC+4)[31:28], bits [25:0], 2'b00}.
- R8: Register 0 always reads as zero. A write aimed at it is reported on the commit port but leaves it zero.
- R9: Any opcode outside the five above writes nothing and advances the PC by 4.
- R10: Source registers are read before the write of the same instruction, so an instruction whose destination is also a source sees the old value.
- R11: Before each edge, `rf_we_o`/`rf_waddr_o`/`rf_wdata_o` show the register write of the current instruction, and `dm_we_o`/`dm_addr_o`/`dm_wdata_o` show its memory write (byte address and data).
- R12: The load port writes word `ld_addr` of instruction or data storage on a clock edge. `dbg_rdata` shows register `dbg_rsel` and `dbg_mdata` shows data word `dbg_maddr`, both combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_imem_we | input | 1 | Load-port write strobe for instruction storage |
| ld_dmem_we | input | 1 | Load-port write strobe for data storage (wins over a store) |
| ld_addr | input | LD_AW | Word index for the load port |
| ld_data | input | 32 | Word written by the load port |
| pc_o | output | 32 | Current program counter |
| instr_o | output | 32 | Instruction at the current PC |
| rf_we_o | output | 1 | Current instruction writes a register |
| rf_waddr_o | output | 5 | Destination register number |
| rf_wdata_o | output | 32 | Value written to the destination |
| dm_we_o | output | 1 | Current instruction writes data storage |
| dm_addr_o | output | 32 | Byte address computed by the ALU |
| dm_wdata_o | output | 32 | Store data |
| dbg_rsel | input | 5 | Register number to inspect |
| dbg_rdata | output | 32 | Value of the inspected register |
| dbg_maddr | input | DMEM_AW | Data word index to inspect |
| dbg_mdata | output | 32 | Value of the inspected data word |

## Verification
Every piece of state in this core (PC, registers, data words) feeds the commit outputs of the very next instruction that uses it. A wrong PC therefore shows on `pc_o` one cycle after the faulty edge. A wrong register value shows on `rf_wdata_o`, `dm_addr_o` or the branch direction the first time a later instruction reads that register, which the programs arrange within a few cycles. The bench steps a behavioural model on every clock and compares the full commit bundle, so a decode, ALU or next-PC fault is caught in the cycle of the first instruction it affects. A final sweep of the inspection ports catches state that no later instruction happened to read.

// File: rtl/cpu_pkg.sv
package cpu_pkg;

  localparam int XLEN   = 32;
  localparam int NREG   = 32;
  localparam int REG_AW = $clog2(NREG);
  localparam int OPW    = 6;

  typedef enum logic [2:0] {
    ALU_AND = 3'b000,
    ALU_OR  = 3'b001,
    ALU_ADD = 3'b010,
    ALU_SUB = 3'b110,
    ALU_SLT = 3'b111
  } alu_op_e;

  typedef enum logic [1:0] {
    AOP_ADD   = 2'b00,
    AOP_SUB   = 2'b01,
    AOP_FUNCT = 2'b10
  } aluop_class_e;

  localparam logic [OPW-1:0] OP_RTYPE = 6'b000000;
  localparam logic [OPW-1:0] OP_LW    = 6'b100011;
  localparam logic [OPW-1:0] OP_SW    = 6'b101011;
  localparam logic [OPW-1:0] OP_BEQ   = 6'b000100;
  localparam logic [OPW-1:0] OP_J     = 6'b000010;

  localparam logic [5:0] FN_ADD = 6'b100000;
  localparam logic [5:0] FN_SUB = 6'b100010;
  localparam logic [5:0] FN_AND = 6'b100100;
  localparam logic [5:0] FN_OR  = 6'b100101;
  localparam logic [5:0] FN_SLT = 6'b101010;

  typedef struct packed {
    logic         dst_rd;   // destination from rd field, else rt
    logic         src_imm;  // ALU operand B is the extended immediate
    logic         wb_mem;   // write-back from data storage, else ALU
    logic         reg_we;
    logic         mem_we;
    logic         branch;
    logic         jump;
    aluop_class_e aop;
  } ctrl_t;

endpackage

// File: rtl/cpu_main_dec.sv
module cpu_main_dec
  import cpu_pkg::*;
(
  input  logic [OPW-1:0] opcode,
  output ctrl_t          ctrl
);

  always_comb begin
    ctrl     = '0;
    ctrl.aop = AOP_ADD;
    case (opcode)
      OP_RTYPE: begin
        ctrl.dst_rd = 1'b1;
        ctrl.reg_we = 1'b1;
        ctrl.aop    = AOP_FUNCT;
      end
      OP_LW: begin
        ctrl.src_imm = 1'b1;
        ctrl.wb_mem  = 1'b1;
        ctrl.reg_we  = 1'b1;
      end
      OP_SW: begin
        ctrl.src_imm = 1'b1;
        ctrl.mem_we  = 1'b1;
      end
      OP_BEQ: begin
        ctrl.branch = 1'b1;
        ctrl.aop    = AOP_SUB;
      end
      OP_J: begin
        ctrl.jump = 1'b1;
      end
      default: ;
    endcase
  end

  // R5: a store never also writes a register; R9/R6: control flow writes nothing
  always_comb begin
    p_one_writer_r5: assert (!(ctrl.reg_we && ctrl.mem_we));
    p_flow_no_write_r6: assert (!((ctrl.branch || ctrl.jump) && (ctrl.reg_we || ctrl.mem_we)));
  end

endmodule

// File: rtl/cpu_alu_dec.sv
module cpu_alu_dec
  import cpu_pkg::*;
(
  input  aluop_class_e aop,
  input  logic [5:0]   funct,
  output alu_op_e      op
);

  always_comb begin
    case (aop)
      AOP_ADD: op = ALU_ADD;
      AOP_SUB: op = ALU_SUB;
      AOP_FUNCT: begin
        case (funct)
          FN_ADD:  op = ALU_ADD;
          FN_SUB:  op = ALU_SUB;
          FN_AND:  op = ALU_AND;
          FN_OR:   op = ALU_OR;
          FN_SLT:  op = ALU_SLT;
          default: op = ALU_ADD;
        endcase
      end
      default: op = ALU_ADD;
    endcase
  end

endmodule

// File: rtl/cpu_alu.sv
module cpu_alu
  import cpu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_op_e      op,
  output logic [W-1:0] y,
  output logic         zero
);

  always_comb begin
    case (op)
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
      default: y = '0;
    endcase
  end

  assign zero = (y == '0);

  // Independent sign/overflow view of the comparison, used only by checks
  logic [W-1:0] chk_diff;
  logic         chk_ovf;
  assign chk_diff = a - b;
  assign chk_ovf  = (a[W-1] ^ b[W-1]) & (chk_diff[W-1] ^ a[W-1]);

  always_comb begin
    if (op == ALU_SUB) begin
      p_sub_zero_r6: assert (zero == (a == b));
    end
    if (op == ALU_SLT) begin
      p_slt_sign_r3: assert (y == {{(W-1){1'b0}}, chk_diff[W-1] ^ chk_ovf});
    end
  end

endmodule

// File: rtl/cpu_regfile.sv
module cpu_regfile #(
  parameter int N  = 32,
  parameter int W  = 32,
  parameter int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] ra1,
  output logic [W-1:0]  rd1,
  input  logic [AW-1:0] ra2,
  output logic [W-1:0]  rd2,
  input  logic [AW-1:0] ra3,
  output logic [W-1:0]  rd3
);

  logic [W-1:0] regs [N];

  always_ff @(posedge clk) begin
    if (we && (waddr != '0)) begin
      regs[waddr] <= wdata;
    end
  end

  assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
  assign rd2 = (ra2 == '0) ? '0 : regs[ra2];
  assign rd3 = (ra3 == '0) ? '0 : regs[ra3];

  // R2: a write to a nonzero register is present after the edge
  p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (we && (waddr != '0)) |=> (regs[$past(waddr)] == $past(wdata)));

endmodule

// File: rtl/cpu_core.sv
module cpu_core
  import cpu_pkg::*;
#(
  parameter int IMEM_AW = 6,
  parameter int DMEM_AW = 6,
  parameter int LD_AW   = (IMEM_AW > DMEM_AW) ? IMEM_AW : DMEM_AW
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ld_imem_we,
  input  logic               ld_dmem_we,
  input  logic [LD_AW-1:0]   ld_addr,
  input  logic [XLEN-1:0]    ld_data,
  output logic [XLEN-1:0]    pc_o,
  output logic [XLEN-1:0]    instr_o,
  output logic               rf_we_o,
  output logic [REG_AW-1:0]  rf_waddr_o,
  output logic [XLEN-1:0]    rf_wdata_o,
  output logic               dm_we_o,
  output logic [XLEN-1:0]    dm_addr_o,
  output logic [XLEN-1:0]    dm_wdata_o,
  input  logic [REG_AW-1:0]  dbg_rsel,
  output logic [XLEN-1:0]    dbg_rdata,
  input  logic [DMEM_AW-1:0] dbg_maddr,
  output logic [XLEN-1:0]    dbg_mdata
);

  localparam int IMEM_WORDS = 1 << IMEM_AW;
  localparam int DMEM_WORDS = 1 << DMEM_AW;

  // ---------------- reset release synchroniser ----------------
  logic rst_s1, run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      run_q  <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      run_q  <= rst_s1;
    end
  end

  // ---------------- storage ----------------
  logic [XLEN-1:0] imem [IMEM_WORDS];
  logic [XLEN-1:0] dmem [DMEM_WORDS];

  // ---------------- fetch ----------------
  logic [XLEN-1:0] pc_q, pc_d, pc4, instr;
  assign instr = imem[pc_q[IMEM_AW+1:2]];
  assign pc4   = pc_q + 32'd4;

  logic [OPW-1:0]    f_op;
  logic [REG_AW-1:0] f_rs, f_rt, f_rd;
  logic [5:0]        f_fn;
  logic [15:0]       f_imm;
  logic [25:0]       f_tgt;
  assign f_op  = instr[31:26];
  assign f_rs  = instr[25:21];
  assign f_rt  = instr[20:16];
  assign f_rd  = instr[15:11];
  assign f_fn  = instr[5:0];
  assign f_imm = instr[15:0];
  assign f_tgt = instr[25:0];

  // ---------------- decode ----------------
  ctrl_t   ctrl;
  alu_op_e alu_op;

  cpu_main_dec u_main_dec (
    .opcode (f_op),
    .ctrl   (ctrl)
  );

  cpu_alu_dec u_alu_dec (
    .aop   (ctrl.aop),
    .funct (f_fn),
    .op    (alu_op)
  );

  // ---------------- register file ----------------
  logic [XLEN-1:0]   rs_val, rt_val, wb_data;
  logic [REG_AW-1:0] wb_reg;
  logic              wb_en;

  assign wb_reg = ctrl.dst_rd ? f_rd : f_rt;
  assign wb_en  = ctrl.reg_we & run_q;

  cpu_regfile #(.N(NREG), .W(XLEN), .AW(REG_AW)) u_regfile (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wb_en),
    .waddr (wb_reg),
    .wdata (wb_data),
    .ra1   (f_rs),
    .rd1   (rs_val),
    .ra2   (f_rt),
    .rd2   (rt_val),
    .ra3   (dbg_rsel),
    .rd3   (dbg_rdata)
  );

  // ---------------- execute ----------------
  logic [XLEN-1:0] imm_sx, alu_b, alu_y;
  logic            alu_zero;

  assign imm_sx = {{(XLEN-16){f_imm[15]}}, f_imm};
  assign alu_b  = ctrl.src_imm ? imm_sx : rt_val;

  cpu_alu #(.W(XLEN)) u_alu (
    .a    (rs_val),
    .b    (alu_b),
    .op   (alu_op),
    .y    (alu_y),
    .zero (alu_zero)
  );

  // ---------------- data memory ----------------
  logic [DMEM_AW-1:0] dm_idx;
  logic [XLEN-1:0]    dm_rdata;
  logic               dm_en;

  assign dm_idx   = alu_y[DMEM_AW+1:2];
  assign dm_rdata = dmem[dm_idx];
  assign dm_en    = ctrl.mem_we & run_q;
  assign wb_data  = ctrl.wb_mem ? dm_rdata : alu_y;

  always_ff @(posedge clk) begin
    if (ld_dmem_we) begin
      dmem[ld_addr[DMEM_AW-1:0]] <= ld_data;
    end else if (dm_en) begin
      dmem[dm_idx] <= rt_val;
    end
  end

  always_ff @(posedge clk) begin
    if (ld_imem_we) begin
      imem[ld_addr[IMEM_AW-1:0]] <= ld_data;
    end
  end

  assign dbg_mdata = dmem[dbg_maddr];

  // ---------------- next PC ----------------
  logic [XLEN-1:0] br_tgt, j_tgt;
  logic            br_take;

  assign br_tgt  = pc4 + {imm_sx[XLEN-3:0], 2'b00};
  assign j_tgt   = {pc4[31:28], f_tgt, 2'b00};
  assign br_take = ctrl.branch & alu_zero;

  always_comb begin
    if (ctrl.jump)   pc_d = j_tgt;
    else if (br_take) pc_d = br_tgt;
    else              pc_d = pc4;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= '0;
    end else if (run_q) begin
      pc_q <= pc_d;
    end
  end

  // ---------------- outputs ----------------
  assign pc_o       = pc_q;
  assign instr_o    = instr;
  assign rf_we_o    = wb_en;
  assign rf_waddr_o = wb_reg;
  assign rf_wdata_o = wb_data;
  assign dm_we_o    = dm_en;
  assign dm_addr_o  = alu_y;
  assign dm_wdata_o = rt_val;

  // ---------------- checks ----------------
  p_sync_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |=> (pc_q == '0));

  p_seq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !ctrl.jump && !ctrl.branch) |=> (pc_q == $past(pc_q) + 32'd4));

  p_jump_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && ctrl.jump) |=> (pc_q[27:0] == {$past(f_tgt), 2'b00}));

  p_branch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && ctrl.branch && (rs_val == rt_val)) |=>
      (pc_q == $past(pc_q) + 32'd4 + {$past(imm_sx[XLEN-3:0]), 2'b00}));

  always_comb begin
    if (ctrl.branch) begin
      p_branch_sub_r6: assert (alu_op == ALU_SUB);
    end
    if (ctrl.mem_we || ctrl.wb_mem) begin
      p_addr_add_r4: assert (alu_op == ALU_ADD);
    end
  end

endmodule

// File: tb/cpu_core_bench.sv
module cpu_core_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ld_imem_we, ld_dmem_we;
  logic [5:0]  ld_addr;
  logic [31:0] ld_data;
  logic [31:0] pc_o, instr_o, rf_wdata_o, dm_addr_o, dm_wdata_o, dbg_rdata, dbg_mdata;
  logic        rf_we_o, dm_we_o;
  logic [4:0]  rf_waddr_o, dbg_rsel;
  logic [5:0]  dbg_maddr;

  always #2 clk = ~clk;

  cpu_core u_cpu_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .ld_imem_we (ld_imem_we),
    .ld_dmem_we (ld_dmem_we),
    .ld_addr    (ld_addr),
    .ld_data    (ld_data),
    .pc_o       (pc_o),
    .instr_o    (instr_o),
    .rf_we_o    (rf_we_o),
    .rf_waddr_o (rf_waddr_o),
    .rf_wdata_o (rf_wdata_o),
    .dm_we_o    (dm_we_o),
    .dm_addr_o  (dm_addr_o),
    .dm_wdata_o (dm_wdata_o),
    .dbg_rsel   (dbg_rsel),
    .dbg_rdata  (dbg_rdata),
    .dbg_maddr  (dbg_maddr),
    .dbg_mdata  (dbg_mdata)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [31:0] m_imem [64];
  logic [31:0] m_dmem [64];
  logic [31:0] m_regs [32];
  bit          m_written [32];
  logic [31:0] m_pc;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_r(input logic [4:0] rs, input logic [4:0] rt,
                                        input logic [4:0] rd, input logic [5:0] fn);
    return {6'b000000, rs, rt, rd, 5'd0, fn};
  endfunction

  function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rs,
                                        input logic [4:0] rt, input logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  function automatic logic [31:0] rv(input logic [4:0] r);
    return (r == 5'd0) ? 32'd0 : m_regs[r];
  endfunction

  // One instruction of the behavioural model, compared with the commit outputs
  task automatic step_model();
    logic [31:0] ins, pc4, sx, a, b, npc, wd, ma, md, la;
    logic [5:0]  op, fn;
    logic [4:0]  rs, rt, rd, wa;
    bit          we, mwe;
    string       tag;
    ins = m_imem[m_pc[7:2]];
    op  = ins[31:26]; rs = ins[25:21]; rt = ins[20:16]; rd = ins[15:11]; fn = ins[5:0];
    sx  = {{16{ins[15]}}, ins[15:0]};
    pc4 = m_pc + 32'd4;
    a = rv(rs); b = rv(rt);
    we = 0; mwe = 0; wa = 0; wd = 0; ma = 0; md = 0; npc = pc4; tag = "R9";
    case (op)
      6'b000000: begin
        we = 1; wa = rd; tag = "R2";
        case (fn)
          6'b100000: wd = a + b;
          6'b100010: wd = a - b;
          6'b100100: wd = a & b;
          6'b100101: wd = a | b;
          6'b101010: begin wd = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0; tag = "R3"; end
          default:   wd = a + b;
        endcase
        if (rd == rs || rd == rt) tag = "R10";
      end
      6'b100011: begin
        la = a + sx; we = 1; wa = rt; wd = m_dmem[la[7:2]]; tag = "R4";
      end
      6'b101011: begin
        mwe = 1; ma = a + sx; md = b; tag = "R5";
      end
      6'b000100: begin
        tag = "R6";
        if (a == b) npc = pc4 + {sx[29:0], 2'b00};
      end
      6'b000010: begin
        tag = "R7";
        npc = {pc4[31:28], ins[25:0], 2'b00};
      end
      default: ;
    endcase
    if (we && wa == 5'd0) tag = "R8";

    chk(pc_o === m_pc, tag, pc_o, m_pc);
    chk(rf_we_o === we, {tag, "/R11 rf_we"}, {31'd0, rf_we_o}, {31'd0, we});
    if (we) begin
      chk(rf_waddr_o === wa, {tag, "/R11 waddr"}, {27'd0, rf_waddr_o}, {27'd0, wa});
      chk(rf_wdata_o === wd, {tag, "/R11 wdata"}, rf_wdata_o, wd);
    end
    chk(dm_we_o === mwe, {tag, "/R11 dm_we"}, {31'd0, dm_we_o}, {31'd0, mwe});
    if (mwe) begin
      chk(dm_addr_o === ma, {tag, "/R11 dm_addr"}, dm_addr_o, ma);
      chk(dm_wdata_o === md, {tag, "/R11 dm_wdata"}, dm_wdata_o, md);
    end

    if (we && wa != 5'd0) begin m_regs[wa] = wd; m_written[wa] = 1'b1; end
    if (mwe) m_dmem[ma[7:2]] = md;
    m_pc = npc;
  endtask

  task automatic run_cycles(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      step_model();
    end
  endtask

  // Two edges of synchroniser latency: one negedge with writes still gated
  task automatic release_reset();
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(pc_o === 32'd0, "R1 pc after release", pc_o, 32'd0);
    chk(rf_we_o === 1'b0 && dm_we_o === 1'b0, "R1 writes gated", {30'd0, rf_we_o, dm_we_o}, 32'd0);
    m_pc = 32'd0;
  endtask

  initial begin
    rst_n = 1'b0; ld_imem_we = 0; ld_dmem_we = 0; ld_addr = '0; ld_data = '0;
    dbg_rsel = '0; dbg_maddr = '0;
    for (int i = 0; i < 64; i++) begin m_imem[i] = 32'd0; m_dmem[i] = 32'd0; end
    for (int i = 0; i < 32; i++) begin m_regs[i] = 32'd0; m_written[i] = 1'b0; end

    m_dmem[0]  = 32'd5;
    m_dmem[1]  = 32'hFFFF_FFFD;
    m_dmem[2]  = 32'h1234_5678;
    m_dmem[63] = 32'd777;

    m_imem[0]  = enc_i(6'b100011, 5'd0, 5'd1, 16'd0);      // lw r1,0(r0)
    m_imem[1]  = enc_i(6'b100011, 5'd0, 5'd2, 16'd4);      // lw r2,4(r0)
    m_imem[2]  = enc_r(5'd1, 5'd2, 5'd3, 6'b100000);       // add
    m_imem[3]  = enc_r(5'd1, 5'd2, 5'd4, 6'b100010);       // sub
    m_imem[4]  = enc_r(5'd1, 5'd2, 5'd5, 6'b100100);       // and
    m_imem[5]  = enc_r(5'd1, 5'd2, 5'd6, 6'b100101);       // or
    m_imem[6]  = enc_r(5'd2, 5'd1, 5'd7, 6'b101010);       // slt -3<5
    m_imem[7]  = enc_r(5'd1, 5'd2, 5'd8, 6'b101010);       // slt 5<-3
    m_imem[8]  = enc_r(5'd1, 5'd1, 5'd0, 6'b100000);       // write r0
    m_imem[9]  = enc_r(5'd0, 5'd1, 5'd9, 6'b100000);       // r9 = r0+r1
    m_imem[10] = enc_i(6'b101011, 5'd0, 5'd3, 16'd8);      // sw r3,8(r0)
    m_imem[11] = enc_i(6'b100011, 5'd0, 5'd10, 16'd252);   // lw r10,252(r0)
    m_imem[12] = enc_i(6'b100011, 5'd4, 5'd11, 16'hFFFC);  // lw r11,-4(r4)
    m_imem[13] = enc_r(5'd1, 5'd9, 5'd12, 6'b101010);      // slt equal
    m_imem[14] = enc_i(6'b000100, 5'd1, 5'd9, 16'd2);      // beq taken
    m_imem[15] = enc_r(5'd1, 5'd1, 5'd13, 6'b100000);
    m_imem[16] = enc_r(5'd1, 5'd1, 5'd13, 6'b100000);
    m_imem[17] = enc_i(6'b000100, 5'd1, 5'd2, 16'd5);      // beq not taken
    m_imem[18] = {6'b000010, 26'd21};                      // j 21
    m_imem[19] = enc_r(5'd1, 5'd1, 5'd14, 6'b100000);
    m_imem[20] = enc_r(5'd1, 5'd1, 5'd14, 6'b100000);
    m_imem[21] = enc_r(5'd1, 5'd1, 5'd1, 6'b100000);       // r1 = r1+r1
    m_imem[22] = enc_i(6'b001000, 5'd1, 5'd15, 16'd7);     // unlisted opcode
    m_imem[23] = enc_i(6'b000100, 5'd0, 5'd0, 16'hFFFF);   // self loop

    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      ld_imem_we = 1'b1; ld_dmem_we = 1'b1; ld_addr = i[5:0];
      ld_data = m_imem[i];
      @(negedge clk);
      ld_imem_we = 1'b0; ld_data = m_dmem[i];
    end
    @(negedge clk);
    ld_dmem_we = 1'b0;

    chk(pc_o === 32'd0, "R1 pc in reset", pc_o, 32'd0);
    chk(rf_we_o === 1'b0 && dm_we_o === 1'b0, "R1 no write in reset", {30'd0, rf_we_o, dm_we_o}, 32'd0);

    dbg_maddr = 6'd63;
    #1 chk(dbg_mdata === 32'd777, "R12 loaded data word", dbg_mdata, 32'd777);

    release_reset();
    run_cycles(36);

    // mid-run reset forces PC to 0 at once; state is retained
    @(negedge clk);
    rst_n = 1'b0;
    #1 chk(pc_o === 32'd0, "R1 async pc clear", pc_o, 32'd0);
    release_reset();
    run_cycles(36);

    @(negedge clk);
    for (int r = 0; r < 32; r++) begin
      dbg_rsel = r[4:0];
      #1;
      if (r == 0)
        chk(dbg_rdata === 32'd0, "R8 r0 stays zero", dbg_rdata, 32'd0);
      else if (m_written[r])
        chk(dbg_rdata === m_regs[r], "R12 register sweep", dbg_rdata, m_regs[r]);
    end
    for (int w = 0; w < 64; w++) begin
      dbg_maddr = w[5:0];
      #1 chk(dbg_mdata === m_dmem[w], "R12 data sweep", dbg_mdata, m_dmem[w]);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule